// File: doc/BRIEF.md
# Every-Second-One Pulse Detector

This block watches a one-bit serial input and raises a one-cycle pulse on every second cycle in which that input is high. The count restarts after a clear. A single stored bit holds the parity of the ones seen since the last clear, either even or odd. The pulse is a Mealy output. It rises in the same cycle as the qualifying one, when the stored parity is already odd.

The clear is the synchronous active-low input `rst_n`. A cycle with `rst_n` low forces the parity to even and suppresses the pulse. A high `din` in that same cycle is dropped, so counting starts on the first clock after `rst_n` returns high.

Two storage variants behave the same at the ports, and a parameter picks one. The first feeds computed next-state logic into a D flop. The second derives set and clear terms from the JK excitation table and drives a JK-style flop with them.

Top module: `pair_pulse_det`

## Requirements
- R1: After any cycle with `rst_n` low, the stored parity is even, so the first cycle afterwards with `din` high gives `pulse` = 0.
- R2: A cycle with `rst_n` low and `din` high does not count that one: the next one after the clear still gives `pulse` = 0.
- R3: With `rst_n` high, `pulse` = 1 exactly in a cycle where `din` = 1 and the parity is odd, so a run of ones yields 0, 1, 0, 1, and so on.
- R4: A cycle with `rst_n` high and `din` = 0 gives `pulse` = 0 and leaves the parity unchanged.
- R5: `pulse` is 0 in every cycle with `rst_n` low, whatever `din` and the parity are.
- R6: The D variant (`STORE` = `STORE_D`) and the JK variant (`STORE` = `STORE_JK`) give the same `pulse` in every cycle for the same input history.
- R7: Consecutive clear cycles leave the parity even, and counting resumes normally after the last of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge only |
| rst_n | input | 1 | Synchronous active-low clear of the parity |
| din | input | 1 | Serial data bit whose high cycles are counted |
| pulse | output | 1 | High on every second counted one (Mealy) |

## Verification
The clear and a counted one can land in the same cycle, and the clear must win. When the clear comes while the parity is odd, it must also prevent the pulse that `din` alone would have produced. The bench drives `rst_n` low together with `din` high, both with even parity and with odd parity. It then judges the result by the pulse in that cycle, which must be 0, and by the next two ones after the clear, which must give 0 and then 1. Both variants run side by side on the same stimulus, so a difference between them is also reported in the cycle where it appears.

// File: rtl/pp_pkg.sv
// Package: shared types for the every-second-one pulse detector.
// Assumes: nothing; pure type definitions.
package pp_pkg;

    // Parity of the ones counted since the last clear.
    typedef enum logic {
        PAR_EVEN = 1'b0,
        PAR_ODD  = 1'b1
    } parity_e;

    // Storage variant selector for the parity bit.
    typedef enum logic {
        STORE_D  = 1'b0,
        STORE_JK = 1'b1
    } store_e;

endpackage

// File: rtl/pp_next_state.sv
// Module: next-parity logic for the D-flop variant.
// Purpose: clear forces even; otherwise a high input flips the parity.
// Assumes: rst_n is synchronous and active low.
module pp_next_state
    import pp_pkg::*;
(
    input  logic    rst_n,
    input  logic    din,
    input  parity_e cur_par,
    output parity_e nxt_par
);

    // Compute the parity to load at the next rising edge.
    always_comb begin
        if (!rst_n) begin
            nxt_par = PAR_EVEN;
        end else if (din) begin
            nxt_par = (cur_par == PAR_ODD) ? PAR_EVEN : PAR_ODD;
        end else begin
            nxt_par = cur_par;
        end
    end

endmodule

// File: rtl/pp_d_store.sv
// Module: D-type storage for the parity bit.
// Purpose: loads the precomputed next parity on every rising edge.
// Assumes: the clear is already folded into nxt_par by the caller.
module pp_d_store
    import pp_pkg::*;
(
    input  logic    clk,
    input  parity_e nxt_par,
    output parity_e par_q
);

    // Register the next parity.
    always_ff @(posedge clk) begin
        par_q <= nxt_par;
    end

endmodule

// File: rtl/pp_jk_store.sv
// Module: JK-type storage for the parity bit with its excitation logic.
// Purpose: sets on a counted one from even, clears on a counted one from
//          odd or on a clear cycle; holds otherwise.
// Assumes: rst_n is synchronous and active low.
module pp_jk_store
    import pp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    din,
    output parity_e par_q
);

    logic set_j;
    logic clr_k;

    // Excitation terms: J moves even to odd, K moves odd to even or clears.
    always_comb begin
        set_j = rst_n & din;
        clr_k = (~rst_n) | din;
    end

    // JK flop behaviour: hold, reset, set, toggle.
    always_ff @(posedge clk) begin
        unique case ({set_j, clr_k})
            2'b00:   par_q <= par_q;
            2'b01:   par_q <= PAR_EVEN;
            2'b10:   par_q <= PAR_ODD;
            default: par_q <= (par_q == PAR_ODD) ? PAR_EVEN : PAR_ODD;
        endcase
    end

endmodule

// File: rtl/pp_out.sv
// Module: Mealy output stage of the pulse detector.
// Purpose: pulse when a counted one arrives while the parity is odd.
// Assumes: a clear cycle never pulses.
module pp_out
    import pp_pkg::*;
(
    input  logic    rst_n,
    input  logic    din,
    input  parity_e par_q,
    output logic    pulse
);

    // Combine the live input with the stored parity.
    always_comb begin
        pulse = rst_n && din && (par_q == PAR_ODD);
    end

endmodule

// File: rtl/pair_pulse_det.sv
// Module: every-second-one pulse detector (top).
// Purpose: counts high cycles of din modulo two since the last clear and
//          pulses on each second one; STORE picks D or JK storage.
// Assumes: rst_n is synchronous, active low, and held low at start-up.
module pair_pulse_det
    import pp_pkg::*;
#(
    parameter store_e STORE = STORE_D
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic pulse
);

    parity_e parity_q;

    // Storage variant chosen at elaboration time.
    generate
        if (STORE == STORE_JK) begin : g_jk
            pp_jk_store u_store (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (din),
                .par_q (parity_q)
            );
        end else begin : g_d
            parity_e nxt_par;

            pp_next_state u_next (
                .rst_n   (rst_n),
                .din     (din),
                .cur_par (parity_q),
                .nxt_par (nxt_par)
            );

            pp_d_store u_store (
                .clk     (clk),
                .nxt_par (nxt_par),
                .par_q   (parity_q)
            );
        end
    endgenerate

    pp_out u_out (
        .rst_n (rst_n),
        .din   (din),
        .par_q (parity_q),
        .pulse (pulse)
    );

endmodule

// File: rtl/pp_checker.sv
// Module: assertion checker for pair_pulse_det, attached by bind.
// Purpose: relates the stored parity, input and pulse across cycles.
// Assumes: rst_n is held low on the first clock edge.
module pp_checker
    import pp_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input logic    din,
    input logic    pulse,
    input parity_e parity_q
);

    logic was_clr = 1'b0;

    // Remember whether the previous edge saw a clear.
    always @(posedge clk) begin
        was_clr <= !rst_n;
    end

    // R5: no pulse during a clear cycle.
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_quiet_in_clear_R5: assert (!pulse)
                else $error("pulse high during clear");
        end
    end

    // R1 / R7: the edge after a clear cycle leaves the parity even.
    always @(posedge clk) begin
        if (was_clr) begin
            assert_clear_gives_even_R1: assert (parity_q == PAR_EVEN)
                else $error("parity not even after clear");
        end
    end

    // R3: a counted one flips the parity.
    assert_one_flips_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && din) |=> (parity_q != $past(parity_q)));

    // R4: a zero leaves the parity unchanged.
    assert_zero_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !din) |=> $stable(parity_q));

    // R3: after a pulse the count is back to even.
    assert_pulse_returns_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> (parity_q == PAR_EVEN));

    // R3: a counted one without a pulse leaves the count odd.
    assert_silent_one_goes_odd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (din && !pulse) |=> (parity_q == PAR_ODD));

endmodule

bind pair_pulse_det pp_checker i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (din),
    .pulse    (pulse),
    .parity_q (parity_q)
);

// File: tb/test_pair_pulse_det.sv
// Bench: drives the D and JK variants in lockstep with directed scenarios
// and a random run, checking each against hand values or a parity model.
module test_pair_pulse_det;
    import pp_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 20000;
    localparam int RANDOM_CYCLES = 600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b0;
    logic pulse_d;
    logic pulse_jk;

    int n_checks = 0;
    int n_fail = 0;
    bit ref_odd = 1'b0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pair_pulse_det #(.STORE(STORE_D)) i_pair_pulse_det (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (din),
        .pulse (pulse_d)
    );

    pair_pulse_det #(.STORE(STORE_JK)) i_pair_pulse_det_jk (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (din),
        .pulse (pulse_jk)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    // One cycle: drive inputs after the falling edge, check both variants.
    task automatic step(input logic r, input logic i, input logic exp_s, input string req);
        @(negedge clk);
        rst_n = r;
        din = i;
        #1;
        check({req, " D form"}, pulse_d, exp_s);
        check({req, " JK form"}, pulse_jk, exp_s);
        check("R6 variants agree", pulse_d, pulse_jk);
        ref_odd = r ? (ref_odd ^ i) : 1'b0;
    endtask

    task automatic t_reset_state;
        step(1'b0, 1'b0, 1'b0, "R5 clear quiet");
        step(1'b1, 1'b1, 1'b0, "R1 first one after clear");
        step(1'b1, 1'b1, 1'b1, "R3 second one");
    endtask

    task automatic t_clear_swallows_one;
        step(1'b0, 1'b1, 1'b0, "R5 clear with din high");
        step(1'b1, 1'b1, 1'b0, "R2 one after clear not second");
        step(1'b1, 1'b1, 1'b1, "R3 second one after clear");
    endtask

    task automatic t_clear_from_odd;
        step(1'b0, 1'b0, 1'b0, "R5 clear");
        step(1'b1, 1'b1, 1'b0, "R3 first one");
        step(1'b0, 1'b1, 1'b0, "R5 clear while odd with din high");
        step(1'b1, 1'b1, 1'b0, "R2 count restarted");
        step(1'b1, 1'b1, 1'b1, "R3 pulse after restart");
    endtask

    task automatic t_zeros_hold;
        step(1'b0, 1'b0, 1'b0, "R5 clear");
        step(1'b1, 1'b1, 1'b0, "R3 first one");
        step(1'b1, 1'b0, 1'b0, "R4 zero while odd");
        step(1'b1, 1'b0, 1'b0, "R4 zero while odd");
        step(1'b1, 1'b1, 1'b1, "R4 odd held across zeros");
        step(1'b1, 1'b0, 1'b0, "R4 zero while even");
        step(1'b1, 1'b1, 1'b0, "R4 even held across zero");
    endtask

    task automatic t_run_of_ones;
        step(1'b0, 1'b0, 1'b0, "R5 clear");
        for (int k = 0; k < 8; k++) begin
            step(1'b1, 1'b1, logic'(k % 2), "R3 alternating run");
        end
    endtask

    task automatic t_back_to_back_clear;
        step(1'b1, 1'b1, ref_odd ? 1'b1 : 1'b0, "R3 prime");
        step(1'b0, 1'b1, 1'b0, "R7 clear 1");
        step(1'b0, 1'b0, 1'b0, "R7 clear 2");
        step(1'b0, 1'b1, 1'b0, "R7 clear 3");
        step(1'b1, 1'b1, 1'b0, "R7 first one after clears");
        step(1'b1, 1'b1, 1'b1, "R7 second one after clears");
    endtask

    task automatic t_random;
        for (int k = 0; k < RANDOM_CYCLES; k++) begin
            logic r;
            logic i;
            logic exp_s;
            r = ($urandom_range(0, 7) != 0);
            i = ($urandom_range(0, 2) != 0);
            exp_s = r && i && ref_odd;
            step(r, i, exp_s, "R3 random vs model");
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        t_reset_state();
        t_clear_swallows_one();
        t_clear_from_odd();
        t_zeros_hold();
        t_run_of_ones();
        t_back_to_back_clear();
        t_random();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule